// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A start address is captured on a rising clock edge whenever either of two active-low load strobes is low. One strobe belongs to a processor and the other to a cache controller, and both have the same effect. After the load, an active-low advance input steps a two-bit beat counter through the four words of the burst.

The low two address bits are formed from the loaded offset and the beat counter. The order-select input chooses how they combine. In linear order they are added modulo four. In interleaved order they are XORed. The upper address bits never change during a burst, so every burst stays inside its aligned group of four words.

All inputs, including the order select, pass through registers on the rising clock edge. The address output is therefore a function of registered state only, and it shows the effect of an edge in the cycle that follows it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets. After that edge `addr_out` is 0, `beat` is 0 and linear order is selected.
- R2: If `cpu_load_n` is low at an edge, `addr_in` is captured. After that edge `addr_out` equals the captured value and `beat` is 0.
- R3: If `cache_load_n` is low at an edge, the address is captured exactly as in R2. When both strobes are low, a single load takes place.
- R4: Either strobe takes priority over `step_n`. A load at any beat position returns `beat` to 0 and outputs the new address unchanged.
- R5: If `step_n` is low and both strobes are high at an edge, `beat` increments by one. It wraps from 3 to 0.
- R6: If `step_n` and both strobes are high at an edge, `beat` and `addr_out` keep their values. `addr_in` is ignored in that case.
- R7: When `order_sel` = 0 (linear), `addr_out[1:0]` = (loaded offset + `beat`) mod 4.
- R8: When `order_sel` = 1 (interleaved), `addr_out[1:0]` = loaded offset XOR `beat`.
- R9: `addr_out[AW-1:2]` equals the loaded upper bits for the whole burst, in both orders.
- R10: `order_sel` is registered at every edge. A change applies to the current burst from the next cycle, and the beat position is not altered by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_load_n | input | 1 | Processor load strobe, active low |
| cache_load_n | input | 1 | Cache-controller load strobe, active low |
| step_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_in | input | AW | Start address to capture |
| addr_out | output | AW | Current word address |
| beat | output | 2 | Current beat position within the burst |

## Verification
The case hardest to reach from the ports is a change of `order_sel` in the middle of a burst. It must change the low address bits on the following cycle while the beat position stays where it was. The bench sets up this case in three steps. It loads a burst in linear order and advances it. It then toggles the order while the strobes and advance stay high, and checks that the beat is unchanged while the offset is remapped. A second hard case is a load that arrives at beat 2 together with an advance. The bench drives this combination directly to show that the load takes priority.

// File: rtl/bas_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes a four-beat burst, which is fixed by the two-bit beat counter.
package bas_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bas_base_reg.sv
// Module: bas_base_reg
// Holds the start address of the current burst and the registered order select.
// Assumes the load qualifier is already decoded from the strobes.
module bas_base_reg
    import bas_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          order_in,
    output logic [AW-1:0] base_q,
    output burst_order_e  order_q
);
    // Capture the start address on a load; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load)
            base_q <= addr_in;
    end

    // Register the order select on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            order_q <= ORD_LINEAR;
        else
            order_q <= burst_order_e'(order_in);
    end

    AST_BASE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> base_q == $past(addr_in)); // R2
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load) |-> $stable(base_q)); // R6
endmodule

// File: rtl/bas_beat_counter.sv
// Module: bas_beat_counter
// The burst beat counter. A load clears it and a step advances it, wrapping modulo 4.
// Assumes that when load and step arrive together, the load wins.
module bas_beat_counter
    import bas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  step,
    output beat_t beat_q
);
    // Clear on load, increment on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (load)
            beat_q <= '0;
        else if (step)
            beat_q <= beat_q + beat_t'(1);
    end

    AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> beat_q == '0); // R4
    AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step && !load) |-> beat_q == beat_t'($past(beat_q) + 1)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!step && !load) |-> $stable(beat_q)); // R6
endmodule

// File: rtl/bas_offset_map.sv
// Module: bas_offset_map
// Combinational mapping from the loaded offset and the beat to the word offset.
// Both orders are built and the registered order select picks one of them.
module bas_offset_map
    import bas_pkg::*;
(
    input  beat_t        start_off,
    input  beat_t        beat,
    input  burst_order_e order,
    output beat_t        word_off
);
    beat_t lin_off;
    beat_t ilv_off;

    // Linear order: add modulo the burst length.
    always_comb lin_off = start_off + beat;

    // Interleaved order: one XOR per offset bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_off[i] = start_off[i] ^ beat[i];
    end

    // Select the ordering that is currently registered.
    always_comb word_off = (order == ORD_INTERLEAVE) ? ilv_off : lin_off;
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer. Two active-low strobes load a start address and an
// active-low advance walks a four-beat burst in linear or interleaved order.
// Assumes AW >= 3. The upper address bits stay fixed for the whole burst.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_load_n,
    input  logic          cache_load_n,
    input  logic          step_n,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    beat
);
    localparam int UP_W = AW - BEAT_W;

    logic          load;
    logic          step;
    logic [AW-1:0] base_q;
    burst_order_e  order_q;
    beat_t         beat_q;
    beat_t         word_off;

    // Decode the strobes: either one low requests a load.
    always_comb load = !cpu_load_n || !cache_load_n;
    // Decode the advance request.
    always_comb step = !step_n;

    bas_base_reg #(.AW(AW)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .order_in (order_sel),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    bas_beat_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .beat_q (beat_q)
    );

    bas_offset_map u_map (
        .start_off (base_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order     (order_q),
        .word_off  (word_off)
    );

    // Assemble the output address: fixed upper bits, mapped low bits.
    always_comb addr_out = {base_q[AW-1:BEAT_W], word_off};
    // Report the beat position.
    always_comb beat = beat_q;

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load) |-> addr_out[AW-1:BEAT_W] == $past(addr_out[AW-1:BEAT_W])); // R9
    AST_LOAD_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> addr_out == $past(addr_in)); // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step && !load) && order_q == ORD_LINEAR && $past(order_q) == ORD_LINEAR
        |-> addr_out[1:0] == beat_t'($past(addr_out[1:0]) + 1)); // R7
    AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step && !load) && order_q == ORD_INTERLEAVE && $past(order_q) == ORD_INTERLEAVE
        |-> (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_q ^ $past(beat_q))); // R8
    AST_ORDER_KEEPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!step && !load) && order_q != $past(order_q) |-> $stable(beat_q)); // R10

    initial begin
        AST_AW_MIN: assert (UP_W >= 1); // R9
    end
endmodule

// File: tb/burst_addr_seq_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module burst_addr_seq_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_load_n = 1'b1;
    logic          cache_load_n = 1'b1;
    logic          step_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference order tables: [start*4 + beat]
    localparam logic [1:0] LIN_TAB [16] = '{0,1,2,3, 1,2,3,0, 2,3,0,1, 3,0,1,2};
    localparam logic [1:0] ILV_TAB [16] = '{0,1,2,3, 1,0,3,2, 2,3,0,1, 3,2,1,0};

    always #2 clk = ~clk;  // 250 MHz

    burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
        .clk, .rst_n, .cpu_load_n, .cache_load_n, .step_n, .order_sel,
        .addr_in, .addr_out, .beat
    );

    task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply inputs, then cross one edge and sample 1 ns after it.
    task automatic cyc(input logic c_n, input logic k_n, input logic s_n,
                       input logic ord, input logic [AW-1:0] a);
        cpu_load_n = c_n; cache_load_n = k_n; step_n = s_n; order_sel = ord; addr_in = a;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        cyc(1, 1, 1, 0, '0);
        cyc(0, 0, 0, 1, 20'hFFFFF);
        rst_n = 1'b1;
        cyc(1, 1, 1, 0, '0);
        chk("R1 addr", addr_out, '0);
        chk("R1 beat", AW'(beat), '0);
    endtask

    task automatic t_load_cpu();
        cyc(0, 1, 1, 0, 20'h12345);
        chk("R2 addr", addr_out, 20'h12345);
        chk("R2 beat", AW'(beat), '0);
    endtask

    task automatic t_load_cache();
        cyc(1, 0, 1, 0, 20'h5432E);
        chk("R3 addr", addr_out, 20'h5432E);
        chk("R3 beat", AW'(beat), '0);
        cyc(0, 0, 1, 0, 20'h0BEE1);
        chk("R3 both addr", addr_out, 20'h0BEE1);
        chk("R3 both beat", AW'(beat), '0);
    endtask

    task automatic t_priority();
        cyc(0, 1, 1, 0, 20'hA0000);
        cyc(1, 1, 0, 0, '0);
        cyc(1, 1, 0, 0, '0);
        chk("R5 beat at 2", AW'(beat), 2);
        cyc(0, 1, 0, 0, 20'h77773);
        chk("R4 addr", addr_out, 20'h77773);
        chk("R4 beat", AW'(beat), '0);
        cyc(1, 0, 0, 1, 20'h33332);
        chk("R4 cache addr", addr_out, 20'h33332);
        chk("R4 cache beat", AW'(beat), '0);
    endtask

    task automatic t_hold();
        cyc(0, 1, 1, 0, 20'h44441);
        cyc(1, 1, 0, 0, 20'hFFFFF);
        cyc(1, 1, 1, 0, 20'h00000);
        chk("R6 addr", addr_out, 20'h44442);
        chk("R6 beat", AW'(beat), 1);
        cyc(1, 1, 1, 0, 20'h99999);
        chk("R6 addr again", addr_out, 20'h44442);
        chk("R6 beat again", AW'(beat), 1);
    endtask

    // All four offsets in both orders, five beats so the wrap is covered.
    task automatic t_orders();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] base;
                base = 20'hC35A0 | AW'(s);
                cyc(0, 1, 1, m[0], base);
                for (int b = 0; b < 5; b++) begin
                    logic [1:0] lo;
                    lo = m ? ILV_TAB[s*4 + (b%4)] : LIN_TAB[s*4 + (b%4)];
                    chk(m ? "R8 order" : "R7 order", addr_out, {base[AW-1:2], lo});
                    chk("R9 upper", AW'(addr_out[AW-1:2]), AW'(base[AW-1:2]));
                    chk("R5 beat", AW'(beat), AW'(b % 4));
                    cyc(1, 1, 0, m[0], '0);
                end
            end
        end
    endtask

    task automatic t_mode_switch();
        cyc(0, 1, 1, 0, 20'h11111);
        cyc(1, 1, 0, 0, '0);
        chk("R7 pre-switch", addr_out, 20'h11112);
        cyc(1, 1, 1, 1, '0);
        chk("R10 remap", addr_out, 20'h11110);
        chk("R10 beat kept", AW'(beat), 1);
        cyc(1, 1, 0, 1, '0);
        chk("R10 continue", addr_out, 20'h11113);
        cyc(1, 1, 1, 0, '0);
        chk("R10 back", addr_out, 20'h11113);
        chk("R10 beat", AW'(beat), 2);
    endtask

    initial begin
        t_reset();
        t_load_cpu();
        t_load_cache();
        t_priority();
        t_hold();
        t_orders();
        t_mode_switch();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule